// File: doc/BRIEF.md
# On/Off-Count PWM Generator

This block produces one pulse-width-modulated output. Unlike a period-plus-compare design, the waveform is set by two independent lengths, both counted in input clock cycles: a high phase and a low phase. The output period is their sum. Software programs the block through a small 32-bit register port: a combinational read path, and a write port that takes effect on the clock edge.

Writes to the two count registers land in shadow copies and do not touch the running waveform. The counts become active only after a control write that carries the update flag. When the channel is running, that copy waits for the next phase boundary. When the channel is idle, the copy happens at once. The control register also holds an enable, an output enable and a polarity flip. It also stores two spare flags that have no effect on the waveform.

Top module: `onoff_pwm`

## Requirements
- R1: The control register is at byte offset 0x00, the low-phase count at 0x18 and the high-phase count at 0x1C. Reads return the values last written. For the control register, only bits 0, 2, 5, 9, 10 and 14 are stored; other bits read as zero, and unmapped offsets read zero.
- R2: Suppose a control write sets enable (bit 0) and output enable (bit 14) on an idle channel, and both active counts are non-zero. The output is then high for the high count and low for the low count, starting in the cycle right after that write, and the pattern repeats with a period equal to their sum.
- R3: A write to either count register, or a control write with the update flag (bit 5) clear, leaves the running waveform unchanged.
- R4: Suppose a control write with bit 5 set arrives while the channel runs. The shadow counts become active at the next phase boundary, and the current phase completes with its old length.
- R5: Suppose a control write with bit 5 set arrives while the channel is idle. The shadow counts are copied immediately, so a later enable without bit 5 uses them.
- R6: A high count of zero gives a constant low output. A low count of zero gives a constant high output. When both are zero, the output stays low.
- R7: When bit 0 or bit 14 is clear, the output sits at its inactive level and the counter is held at the start of the high phase.
- R8: Bit 10 inverts the output, both while running and while idle.
- R9: Writing zero to the control register stops the channel, and the output is low from the next cycle.
- R10: Bits 2 and 9 of the control register are stored and read back but do not alter the waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; counts are in cycles of this clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 8 | Register byte offset |
| regWr | input | 1 | Write strobe, acts on the rising edge |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr, combinational |
| pwmOut | output | 1 | PWM output |

## Verification
The hardest case to reach is a deferred commit: an update request that lands mid-phase while the channel runs, with different counts already waiting in the shadows. To get there, the bench first loads one set of counts through an idle commit. It then writes a second set to the shadows and enables the channel without the update flag. On the first cycle of the high phase, it issues the update. The expected trace then shows the old high phase running to its full length before the new lengths appear, and this separates a correct deferral from an immediate copy. A sweep over all count pairs from 0 to 4, in both polarities, restarts from a stop each time. This covers the zero-length phases and the phase start after a restart.

// File: rtl/onoff_pwm_pkg.sv
`timescale 1ns/1ps
package onoff_pwm_pkg;
  localparam int CNT_W  = 32;
  localparam int DATA_W = 32;

  // control bit positions
  localparam int B_EN   = 0;
  localparam int B_MODE = 2;
  localparam int B_UPD  = 5;
  localparam int B_TRIG = 9;
  localparam int B_INV  = 10;
  localparam int B_OE   = 14;

  localparam logic [DATA_W-1:0] CTRL_MASK =
    (DATA_W'(1) << B_EN)  | (DATA_W'(1) << B_MODE) | (DATA_W'(1) << B_UPD) |
    (DATA_W'(1) << B_TRIG) | (DATA_W'(1) << B_INV) | (DATA_W'(1) << B_OE);

  // strobes and shadow data from control to datapath
  typedef struct packed {
    logic             run;
    logic             invert;
    logic             commit;
    logic [CNT_W-1:0] shOn;
    logic [CNT_W-1:0] shOff;
  } pwm_strb_t;
endpackage

// File: rtl/onoff_pwm_ctrl.sv
`timescale 1ns/1ps
module onoff_pwm_ctrl
  import onoff_pwm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CTRL_OFS = 'h00,
  parameter int OFF_OFS  = 'h18,
  parameter int ON_OFS   = 'h1C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output pwm_strb_t         strb
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_OFF  = ADDR_W'(OFF_OFS);
  localparam logic [ADDR_W-1:0] A_ON   = ADDR_W'(ON_OFS);

  logic [DATA_W-1:0] ctrlReg;
  logic [CNT_W-1:0]  shOn, shOff;
  logic wrCtrl, wrOn, wrOff;

  assign wrCtrl = regWr && (regAddr == A_CTRL);
  assign wrOn   = regWr && (regAddr == A_ON);
  assign wrOff  = regWr && (regAddr == A_OFF);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      shOn    <= '0;
      shOff   <= '0;
    end else begin
      if (wrCtrl) ctrlReg <= regWdata & CTRL_MASK;
      if (wrOn)   shOn    <= regWdata[CNT_W-1:0];
      if (wrOff)  shOff   <= regWdata[CNT_W-1:0];
    end
  end

  always_comb begin
    unique case (regAddr)
      A_CTRL:  regRdata = ctrlReg;
      A_ON:    regRdata = DATA_W'(shOn);
      A_OFF:   regRdata = DATA_W'(shOff);
      default: regRdata = '0;
    endcase
  end

  always_comb begin
    strb.run    = ctrlReg[B_EN] & ctrlReg[B_OE];
    strb.invert = ctrlReg[B_INV];
    strb.commit = wrCtrl & regWdata[B_UPD];
    strb.shOn   = shOn;
    strb.shOff  = shOff;
  end

  // R1: control contents only move on a control write
  p_ctrl_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !wrCtrl |=> $stable(ctrlReg));
  // R3: shadow counts only move on their own writes
  p_shadow_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(wrOn || wrOff) |=> ($stable(shOn) && $stable(shOff)));
endmodule

// File: rtl/onoff_pwm_dp.sv
`timescale 1ns/1ps
module onoff_pwm_dp
  import onoff_pwm_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  pwm_strb_t strb,
  output logic      pwmOut
);
  logic [CNT_W-1:0] actOn, actOff, cnt, curLen;
  logic phaseOn, pendReg, pendNow, endPhase, level;

  assign curLen   = phaseOn ? actOn : actOff;
  assign endPhase = (curLen == '0) || (cnt == curLen - CNT_W'(1));
  assign pendNow  = pendReg | strb.commit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actOn   <= '0;
      actOff  <= '0;
      cnt     <= '0;
      phaseOn <= 1'b1;
      pendReg <= 1'b0;
    end else if (!strb.run) begin
      cnt     <= '0;
      phaseOn <= 1'b1;
      pendReg <= 1'b0;
      if (pendNow) begin
        actOn  <= strb.shOn;
        actOff <= strb.shOff;
      end
    end else if (endPhase) begin
      cnt     <= '0;
      phaseOn <= !phaseOn;
      pendReg <= 1'b0;
      if (pendNow) begin
        actOn  <= strb.shOn;
        actOff <= strb.shOff;
      end
    end else begin
      cnt     <= cnt + CNT_W'(1);
      pendReg <= pendNow;
    end
  end

  // zero-length phases collapse to a constant level
  assign level  = phaseOn ? (actOn != '0) : ((actOff == '0) && (actOn != '0));
  assign pwmOut = strb.invert ^ (strb.run & level);

  // R2: counter never exceeds the current phase length
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && curLen != '0) |-> (cnt < curLen));
  // R7: idle holds the counter at the start of the high phase
  p_idle_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.run |=> (cnt == '0 && phaseOn));
  // R4: a pending commit survives until a phase boundary
  p_pend_wait_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && pendNow && !endPhase) |=> pendReg);
  // R5: idle commit copies the shadows at once
  p_idle_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.run && pendNow) |=> (actOn == $past(strb.shOn) && actOff == $past(strb.shOff)));
  // R3: without a commit the active counts do not move
  p_act_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !pendNow |=> ($stable(actOn) && $stable(actOff)));
  // R6: zero high count keeps the output inactive
  p_zero_on_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && actOn == '0) |-> (pwmOut == strb.invert));
endmodule

// File: rtl/onoff_pwm.sv
`timescale 1ns/1ps
module onoff_pwm
  import onoff_pwm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              pwmOut
);
  pwm_strb_t strb;

  onoff_pwm_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWdata(regWdata), .regRdata(regRdata), .strb(strb)
  );

  onoff_pwm_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pwmOut(pwmOut)
  );
endmodule

// File: tb/onoff_pwm_bench.sv
`timescale 1ns/1ps
module onoff_pwm_bench;
  localparam logic [7:0] A_CTRL = 8'h00, A_OFF = 8'h18, A_ON = 8'h1C;
  localparam logic [31:0] EN = 32'h1, MODE = 32'h4, UPD = 32'h20,
                          TRIG = 32'h200, INV = 32'h400, OE = 32'h4000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, regWr, pwmOut;
  logic [7:0] regAddr;
  logic [31:0] regWdata, regRdata;
  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  onoff_pwm u_onoff_pwm (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWdata(regWdata), .regRdata(regRdata), .pwmOut(pwmOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // called at a negedge, returns at the next negedge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    regAddr = a; regWr = 1'b1; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  function automatic logic model(int on, int off, bit inv, int t);
    logic hi;
    if (on == 0) hi = 1'b0;
    else if (off == 0) hi = 1'b1;
    else hi = ((t % (on + off)) < on);
    return hi ^ inv;
  endfunction

  // sample n cycles, first sample in the current cycle, waveform time t0
  task automatic expWave(input string req, input int on, input int off, input bit inv,
                         input int t0, input int n);
    for (int t = 0; t < n; t++) begin
      if (t > 0) @(negedge clk);
      check(req, {31'b0, pwmOut}, {31'b0, model(on, off, inv, t0 + t)});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] seq [6];
    rstN = 1'b0; regWr = 1'b0; regAddr = '0; regWdata = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    check("R7 reset output", {31'b0, pwmOut}, 32'h0);
    rd(A_CTRL, v); check("R1 reset ctrl", v, 32'h0);

    // R1 readback and masking
    wr(A_ON, 32'h1234_5678);
    wr(A_OFF, 32'h0BAD_F00D);
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, v); check("R1 ctrl mask", v, 32'h0000_4625);
    rd(A_ON, v);   check("R1 on read", v, 32'h1234_5678);
    rd(A_OFF, v);  check("R1 off read", v, 32'h0BAD_F00D);
    rd(8'h04, v);  check("R1 unmapped", v, 32'h0);
    @(negedge clk);

    // R2 R6 R8 R9 sweep over small counts and both polarities
    for (int on = 0; on <= 4; on++)
      for (int off = 0; off <= 4; off++)
        for (int inv = 0; inv < 2; inv++) begin
          wr(A_CTRL, 32'h0);
          check("R9 stop", {31'b0, pwmOut}, 32'h0);
          wr(A_ON, on);
          wr(A_OFF, off);
          wr(A_CTRL, EN | OE | UPD | (inv != 0 ? INV : 32'h0));
          if (on == 0 || off == 0) expWave("R6", on, off, inv != 0, 0, 2 * (on + off) + 3);
          else if (inv != 0)       expWave("R8", on, off, 1'b1, 0, 2 * (on + off) + 3);
          else                     expWave("R2", on, off, 1'b0, 0, 2 * (on + off) + 3);
        end

    // R7 gating: only one of enable / output enable, both polarities
    wr(A_ON, 2); wr(A_OFF, 2);
    for (int k = 0; k < 6; k++) begin
      logic [31:0] c;
      c = (k % 3 == 0) ? EN : ((k % 3 == 1) ? OE : 32'h0);
      if (k >= 3) c = c | INV;
      wr(A_CTRL, c | UPD);
      expWave("R7", 0, 1, k >= 3, 0, 6);
    end

    // R3: shadow writes and non-update control write keep the waveform
    wr(A_CTRL, 32'h0);
    wr(A_ON, 2); wr(A_OFF, 3);
    wr(A_CTRL, EN | OE | UPD);
    wr(A_ON, 1);
    wr(A_OFF, 1);
    wr(A_CTRL, EN | OE);
    expWave("R3", 2, 3, 1'b0, 3, 10);
    rd(A_ON, v);  check("R1 shadow on", v, 32'h1);
    rd(A_OFF, v); check("R1 shadow off", v, 32'h1);

    // R5: idle commit, later enable without update uses it
    wr(A_CTRL, 32'h0);
    wr(A_ON, 3); wr(A_OFF, 1);
    wr(A_CTRL, UPD);
    wr(A_ON, 1); wr(A_OFF, 2);
    wr(A_CTRL, EN | OE);
    expWave("R5", 3, 1, 1'b0, 0, 8);

    // R4: commit issued mid high phase waits for the boundary
    wr(A_CTRL, 32'h0);
    wr(A_ON, 3); wr(A_OFF, 3);
    wr(A_CTRL, UPD);
    wr(A_ON, 1); wr(A_OFF, 1);
    wr(A_CTRL, EN | OE);
    wr(A_CTRL, EN | OE | UPD);
    seq = '{32'h1, 32'h1, 32'h0, 32'h1, 32'h0, 32'h1};
    for (int i = 0; i < 6; i++) begin
      if (i > 0) @(negedge clk);
      check("R4 deferred commit", {31'b0, pwmOut}, seq[i]);
    end

    // R10: mode and trigger bits have no effect
    wr(A_CTRL, 32'h0);
    wr(A_ON, 2); wr(A_OFF, 1);
    wr(A_CTRL, EN | OE | UPD | MODE | TRIG);
    expWave("R10", 2, 1, 1'b0, 0, 9);
    rd(A_CTRL, v); check("R10 readback", v, EN | OE | UPD | MODE | TRIG);

    // R9: stop from running
    @(negedge clk);
    wr(A_CTRL, 32'h0);
    expWave("R9", 0, 1, 1'b0, 0, 5);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule